// File: doc/BRIEF.md
# External Interrupt Line Controller

This block maps a large set of already-synchronized pin levels onto a small number of interrupt lines. Each line picks one pin through its own source selector. It watches that pin for a rising transition, a falling transition or both, as configured, and records a hit in a sticky per-line flag.

The flag stays set until software writes a one to that line's bit on the clear strobe. While the flag is set and the line is unmasked, the line's request output stays high, so the interrupt fires again until software services the cause. Software can also raise a line's flag with a trigger strobe. It reads the flag vector to find out which lines caused the interrupt.

Edges are found by comparing the selected level against a registered copy from the previous cycle. A change of the source selector, and the first cycle after reset, never count as an edge.

Top module: `extl_ctrl`

## Requirements
- R1: With the line's rising enable set, a 0-to-1 change of the selected pin, sampled on a clock edge, sets that line's bit in `pend_o` after that same clock edge.
- R2: With the line's falling enable set, a 1-to-0 change of the selected pin sets that line's pending bit after the sampling edge.
- R3: A transition whose direction is not enabled leaves the pending bit unchanged. With both enables set, either direction sets the bit.
- R4: Only the pin whose index equals the line's selector field (line i uses `src_sel_i[i*SEL_W +: SEL_W]`) can set that line. Activity on any other pin has no effect on it.
- R5: A pending bit stays set until a cycle in which the matching `pend_clr_i` bit is 1. With no new cause in that cycle, the bit reads 0 afterwards.
- R6: `irq_o[i]` is 1 in every cycle in which pending bit i and `int_en_i[i]` are both 1.
- R7: With `int_en_i[i]` at 0, `irq_o[i]` stays 0, but edges and triggers still set pending bit i.
- R8: A 1 on `sw_set_i[i]` sets pending bit i after that clock edge, whatever the edge configuration and the mask.
- R9: A set cause (an edge or a trigger) in the same cycle as the clear strobe for that line leaves the bit set.
- R10: A cycle in which a line's selector value changes produces no edge on that line, even if the old and new pins differ in level. Detection then tracks the new pin from the next cycle on.
- R11: After reset all pending bits and requests are 0. A pin that is already high when reset ends does not count as a rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_lvl_i | input | N_PINS | Synchronized pin levels |
| src_sel_i | input | N_LINES*SEL_W | Per-line pin index, line i in bits i*SEL_W upward |
| rise_en_i | input | N_LINES | Per-line rising-edge trigger enable |
| fall_en_i | input | N_LINES | Per-line falling-edge trigger enable |
| int_en_i | input | N_LINES | Per-line request enable (0 masks the line) |
| sw_set_i | input | N_LINES | Software trigger strobe, one cycle per request |
| pend_clr_i | input | N_LINES | Write-one-to-clear strobe for the pending bits |
| pend_o | output | N_LINES | Sticky pending flags |
| irq_o | output | N_LINES | Per-line interrupt request |

## Verification
On every cycle, the assertions check these properties:
- a pending flag survives unless it is cleared (R5);
- the request follows the flag and the mask (R6, R7);
- a software trigger always wins, even over a simultaneous clear (R8, R9);
- a line with no trigger enabled, or with a changing selector, gains no flag (R3, R10).

Only the bench scenarios can show the parts that depend on pin levels over time: the direction of each edge (R1, R2), that unselected pins are ignored (R4), that an edge beats a clear in the same cycle (R9), and that tracking restarts on the newly selected pin and after reset (R10, R11).

// File: rtl/extl_pkg.sv
package extl_pkg;

    typedef struct packed {
        logic rise;
        logic fall;
    } trig_en_t;

    function automatic int sel_width(input int n_pins);
        return (n_pins > 1) ? $clog2(n_pins) : 1;
    endfunction

    // Edge match for a given trigger configuration
    function automatic logic edge_hit(input trig_en_t t, input logic now, input logic was);
        return (t.rise & now & ~was) | (t.fall & ~now & was);
    endfunction

endpackage

// File: rtl/extl_line_tap.sv
module extl_line_tap
    import extl_pkg::*;
#(
    parameter int N_PINS = 16,
    parameter int SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PINS-1:0] pins,
    input  logic [SEL_W-1:0]  sel,
    input  trig_en_t          trig,
    output logic              hit
);
    logic             lvl_now;
    logic             lvl_q;
    logic [SEL_W-1:0] sel_q;
    logic             armed_q;

    always_comb begin
        lvl_now = 1'b0;
        for (int p = 0; p < N_PINS; p++) begin
            if (sel == SEL_W'(p)) lvl_now = pins[p];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q   <= 1'b0;
            sel_q   <= '0;
            armed_q <= 1'b0;
        end else begin
            lvl_q   <= lvl_now;
            sel_q   <= sel;
            armed_q <= 1'b1;
        end
    end

    // A selector change or the first cycle after reset yields no edge
    assign hit = armed_q && (sel == sel_q) && edge_hit(trig, lvl_now, lvl_q);

endmodule

// File: rtl/extl_pend_cell.sv
module extl_pend_cell (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic sw_set,
    input  logic clr,
    input  logic en,
    output logic pend,
    output logic irq
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else     pend_q <= (pend_q & ~clr) | hit | sw_set;
    end

    assign pend = pend_q;
    assign irq  = pend_q & en;

endmodule

// File: rtl/extl_ctrl.sv
module extl_ctrl
    import extl_pkg::*;
#(
    parameter  int N_PINS  = 16,
    parameter  int N_LINES = 4,
    localparam int SEL_W   = sel_width(N_PINS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_PINS-1:0]        pin_lvl_i,
    input  logic [N_LINES*SEL_W-1:0] src_sel_i,
    input  logic [N_LINES-1:0]       rise_en_i,
    input  logic [N_LINES-1:0]       fall_en_i,
    input  logic [N_LINES-1:0]       int_en_i,
    input  logic [N_LINES-1:0]       sw_set_i,
    input  logic [N_LINES-1:0]       pend_clr_i,
    output logic [N_LINES-1:0]       pend_o,
    output logic [N_LINES-1:0]       irq_o
);
    logic [N_LINES-1:0] hit;

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        trig_en_t trig;
        assign trig = '{rise: rise_en_i[i], fall: fall_en_i[i]};

        extl_line_tap #(.N_PINS(N_PINS), .SEL_W(SEL_W)) u_tap (
            .clk  (clk),
            .rst  (rst),
            .pins (pin_lvl_i),
            .sel  (src_sel_i[i*SEL_W +: SEL_W]),
            .trig (trig),
            .hit  (hit[i])
        );

        extl_pend_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .hit    (hit[i]),
            .sw_set (sw_set_i[i]),
            .clr    (pend_clr_i[i]),
            .en     (int_en_i[i]),
            .pend   (pend_o[i]),
            .irq    (irq_o[i])
        );
    end

endmodule

// File: rtl/extl_ctrl_chk.sv
module extl_ctrl_chk #(
    parameter int N_PINS  = 16,
    parameter int N_LINES = 4,
    parameter int SEL_W   = 4
) (
    input logic                     clk,
    input logic                     rst,
    input logic [N_LINES*SEL_W-1:0] src_sel_i,
    input logic [N_LINES-1:0]       rise_en_i,
    input logic [N_LINES-1:0]       fall_en_i,
    input logic [N_LINES-1:0]       int_en_i,
    input logic [N_LINES-1:0]       sw_set_i,
    input logic [N_LINES-1:0]       pend_clr_i,
    input logic [N_LINES-1:0]       pend_o,
    input logic [N_LINES-1:0]       irq_o
);
    logic [N_LINES*SEL_W-1:0] sel_prev;

    always_ff @(posedge clk) begin
        if (rst) sel_prev <= '0;
        else     sel_prev <= src_sel_i;
    end

    for (genvar i = 0; i < N_LINES; i++) begin : g_chk
        a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
            (pend_o[i] && !pend_clr_i[i]) |=> pend_o[i]);

        a_r6_req_on: assert property (@(posedge clk) disable iff (rst)
            (pend_o[i] && int_en_i[i]) |-> irq_o[i]);

        a_r7_masked_quiet: assert property (@(posedge clk) disable iff (rst)
            !int_en_i[i] |-> !irq_o[i]);

        a_r8_sw_sets: assert property (@(posedge clk) disable iff (rst)
            sw_set_i[i] |=> pend_o[i]);

        a_r9_set_beats_clr: assert property (@(posedge clk) disable iff (rst)
            (pend_clr_i[i] && sw_set_i[i]) |=> pend_o[i]);

        a_r3_no_trig_no_set: assert property (@(posedge clk) disable iff (rst)
            (!rise_en_i[i] && !fall_en_i[i] && !pend_o[i] && !sw_set_i[i]) |=> !pend_o[i]);

        a_r10_sel_change_quiet: assert property (@(posedge clk) disable iff (rst)
            (!pend_o[i] && !sw_set_i[i] &&
             (src_sel_i[i*SEL_W +: SEL_W] != sel_prev[i*SEL_W +: SEL_W])) |=> !pend_o[i]);
    end

endmodule

bind extl_ctrl extl_ctrl_chk #(.N_PINS(N_PINS), .N_LINES(N_LINES), .SEL_W(SEL_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .src_sel_i  (src_sel_i),
    .rise_en_i  (rise_en_i),
    .fall_en_i  (fall_en_i),
    .int_en_i   (int_en_i),
    .sw_set_i   (sw_set_i),
    .pend_clr_i (pend_clr_i),
    .pend_o     (pend_o),
    .irq_o      (irq_o)
);

// File: tb/sim_extl_ctrl.sv
`timescale 1ns/1ps
module sim_extl_ctrl;
    localparam int NP = 16;
    localparam int NL = 4;
    localparam int SW = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NP-1:0]   pins = '0;
    logic [NL*SW-1:0] sel = '0;
    logic [NL-1:0]   rise = '0, fall = '0, en = '0, sset = '0, clr = '0;
    logic [NL-1:0]   pend, irq;

    logic [NP-1:0]   n_pins = '0;
    logic [NL*SW-1:0] n_sel = '0;
    logic [NL-1:0]   n_set = '0, n_clr = '0;

    typedef struct {
        logic [NL-1:0] pend;
        logic [NL-1:0] irq;
        string         tag;
    } exp_t;
    exp_t q[$];

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    extl_ctrl #(.N_PINS(NP), .N_LINES(NL)) u0 (
        .clk(clk), .rst(rst), .pin_lvl_i(pins), .src_sel_i(sel),
        .rise_en_i(rise), .fall_en_i(fall), .int_en_i(en),
        .sw_set_i(sset), .pend_clr_i(clr), .pend_o(pend), .irq_o(irq)
    );

    task automatic cmp(input logic [NL-1:0] act, input logic [NL-1:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%b exp=%b", what, act, exp);
        end
    endtask

    // Driver: apply next inputs, push expected state after the coming edge
    task automatic step(input logic [NL-1:0] ep, input logic [NL-1:0] ei, input string tag);
        exp_t e;
        @(negedge clk);
        pins = n_pins; sel = n_sel; sset = n_set; clr = n_clr;
        e.pend = ep; e.irq = ei; e.tag = tag;
        q.push_back(e);
        n_set = '0; n_clr = '0;
    endtask

    // Monitor
    always begin
        @(posedge clk);
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            cmp(pend, e.pend, {e.tag, " pend"});
            cmp(irq,  e.irq,  {e.tag, " irq"});
        end
    end

    initial begin
        #(4 * 5000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        n_sel = {4'd7, 4'd7, 4'd5, 4'd3};
        rise  = 4'b1101;
        fall  = 4'b0110;
        en    = 4'b0111;
        n_pins = 16'h0008;            // pin 3 already high during reset
        pins   = n_pins; sel = n_sel;
        repeat (3) @(posedge clk);
        #1;
        cmp(pend, '0, "R11 reset pend");
        cmp(irq,  '0, "R11 reset irq");
        @(negedge clk);
        rst = 1'b0;
        step(4'b0000, 4'b0000, "R11 high pin after reset");
        n_pins = 16'h0000; step(4'b0000, 4'b0000, "R3 fall on rise-only line");
        n_pins = 16'h0008; step(4'b0001, 4'b0001, "R1 rise line0");
        step(4'b0001, 4'b0001, "R5 R6 sticky hold");
        n_pins = 16'h0000; step(4'b0001, 4'b0001, "R5 fall no change");
        n_clr = 4'b0001;   step(4'b0000, 4'b0000, "R5 clear");
        n_pins = 16'h0020; step(4'b0000, 4'b0000, "R3 rise on fall-only line");
        n_pins = 16'h0000; step(4'b0010, 4'b0010, "R2 fall line1");
        n_pins = 16'h0080; step(4'b1110, 4'b0110, "R3 R7 rise both lines masked");
        n_pins = 16'h0000; n_clr = 4'b1110;
        step(4'b0100, 4'b0100, "R9 R3 edge with clear");
        n_clr = 4'b0100;   step(4'b0000, 4'b0000, "R5 clear line2");
        n_pins = 16'hFF47; step(4'b0000, 4'b0000, "R4 unselected pins");
        n_pins = 16'h0000; step(4'b0000, 4'b0000, "R4 unselected fall");
        n_set = 4'b1000;   step(4'b1000, 4'b0000, "R8 R7 sw set masked");
        n_set = 4'b0001;   step(4'b1001, 4'b0001, "R8 sw set line0");
        n_clr = 4'b1001;   step(4'b0000, 4'b0000, "R5 clear both");
        n_pins = 16'h0001; step(4'b0000, 4'b0000, "R4 pin0 unselected");
        n_sel = {4'd7, 4'd7, 4'd5, 4'd0};
        step(4'b0000, 4'b0000, "R10 sel change no edge");
        step(4'b0000, 4'b0000, "R10 hold after sel change");
        n_pins = 16'h0000; step(4'b0000, 4'b0000, "R10 fall disabled");
        n_pins = 16'h0001; step(4'b0001, 4'b0001, "R10 tracks new pin");
        n_pins = 16'h0008; step(4'b0001, 4'b0001, "R4 old pin ignored");
        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule